// File: doc/BRIEF.md
# Color Lookup Table Host Access Controller

This block gives an 8-bit processor bus read and write access to a 256-entry, 24-bit color lookup table. The table is held inside the block as a register array with two ports. The host port moves one entry as three color bytes in the order red, green, blue. The bytes pass through a three-byte holding register, and an address register advances by one after each complete entry. A second, independent port returns the stored color for a pixel index one clock later. Host traffic never stalls this pixel port.

The host works through four strobes. One loads the address for writing, one loads the address for reading, one writes a color byte and one reads a color byte. The address value travels on the write data bus.

When the address is loaded for reading, the addressed entry is copied into the holding register. This copy is registered and is valid on the next cycle. The address then points at the following entry, so after each blue read the next entry is fetched the same way. A block of consecutive entries can therefore be streamed after a single address load, in either direction.

A mode input selects 6-bit color. In this mode each byte read back has its upper two bits cleared. The stored bits are not changed: all eight written bits are kept.

Top module: `clut_host_port`

## Requirements
- R1: After a write-address load of A, three byte writes (red, green, blue) store the 24-bit word {red, green, blue} in entry A, with red in bits 23:16 and blue in bits 7:0.
- R2: The address advances by one after each completed blue write, so continuous byte writes fill consecutive entries. It does not change when no strobe is active.
- R3: The address wraps from 255 to 0, both when writing and when reading.
- R4: After a read-address load of A, the next three byte reads return the red, green and blue bytes of entry A. The data is valid from the cycle after the load, and the address then equals A+1.
- R5: After each blue read, the next entry is fetched, so continuous byte reads return consecutive entries.
- R6: With the 6-bit mode input at 1, every byte read back has bits 7:6 equal to 0 and bits 5:0 equal to the stored bits.
- R7: Writes made in 6-bit mode store all 8 bits of each byte, and these bits can be read back in 8-bit mode.
- R8: A load of either address returns the color sequence to red. A write sequence that is cut short by such a load leaves the table unchanged.
- R9: The pixel port returns the entry at pix_idx one clock after it is sampled. Host reads and address loads do not change this output.
- R10: After reset, the address is 0, the sequence is at red and the holding register is 0, so host_rdata reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wa_load | input | 1 | Load the address from host_wdata for writing |
| ra_load | input | 1 | Load the address from host_wdata for reading and fetch the entry |
| data_we | input | 1 | Write host_wdata as the current color byte |
| data_re | input | 1 | Read strobe; advances to the next color byte |
| host_wdata | input | 8 | Address or color byte from the host |
| mode6 | input | 1 | 1 selects 6-bit readback |
| host_rdata | output | 8 | Current color byte of the holding register (combinational) |
| pix_idx | input | 8 | Pixel lookup index |
| pix_color | output | 24 | Registered color for pix_idx |

## Verification
The assertions assume one host strobe per cycle. When strobes do coincide, the block resolves them in this priority order: write-address load, read-address load, byte write, byte read. The bench keeps to this rule by pulsing exactly one strobe for one cycle, with idle cycles in between. The bench reads host_rdata while the read strobe is high, before the clock edge that advances the sequence. It reads pix_color only after the index has been held for a full cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;

   localparam int unsigned LANES = 3;
endpackage

// File: rtl/clut_addr_reg.sv
module clut_addr_reg #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              pre_inc,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= pre_inc ? load_val + ONE : load_val;
      end else if (inc) begin
         addr_q <= addr_q + ONE;
      end
   end

   assign addr = addr_q;
endmodule

// File: rtl/clut_color_seq.sv
module clut_color_seq
   import clut_pkg::*;
#(
   parameter int unsigned COLOR_W = 8,
   localparam int unsigned WORD_W = COLOR_W * LANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               step_wr,
   input  logic               step_rd,
   input  logic [COLOR_W-1:0] wbyte,
   input  logic               fill,
   input  logic [WORD_W-1:0]  fill_word,
   output phase_e             phase,
   output logic               last,
   output logic [COLOR_W-1:0] cur_byte,
   output logic [WORD_W-1:0]  commit_word
);
   phase_e            phase_q;
   logic [WORD_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_RED;
      end else if (restart) begin
         phase_q <= PH_RED;
      end else if (step_wr || step_rd) begin
         case (phase_q)
            PH_RED:  phase_q <= PH_GRN;
            PH_GRN:  phase_q <= PH_BLU;
            default: phase_q <= PH_RED;
         endcase
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned LO = (LANES - 1 - g) * COLOR_W;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_q[LO +: COLOR_W] <= '0;
         end else if (fill) begin
            hold_q[LO +: COLOR_W] <= fill_word[LO +: COLOR_W];
         end else if (step_wr && (phase_q == phase_e'(g))) begin
            hold_q[LO +: COLOR_W] <= wbyte;
         end
      end
      assign commit_word[LO +: COLOR_W] =
         (phase_q == phase_e'(g)) ? wbyte : hold_q[LO +: COLOR_W];
   end

   always_comb begin
      case (phase_q)
         PH_RED:  cur_byte = hold_q[2*COLOR_W +: COLOR_W];
         PH_GRN:  cur_byte = hold_q[COLOR_W +: COLOR_W];
         default: cur_byte = hold_q[0 +: COLOR_W];
      endcase
   end

   assign phase = phase_q;
   assign last  = (phase_q == PH_BLU);
endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WORD_W = 24,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] host_raddr,
   output logic [WORD_W-1:0] host_rword,
   input  logic [ADDR_W-1:0] pix_raddr,
   output logic [WORD_W-1:0] pix_rword
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] pix_q;

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      pix_q <= mem[pix_raddr];
   end

   assign host_rword = mem[host_raddr];
   assign pix_rword  = pix_q;
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
   import clut_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned LOW_W   = 6,
   localparam int unsigned WORD_W = COLOR_W * LANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wa_load,
   input  logic               ra_load,
   input  logic               data_we,
   input  logic               data_re,
   input  logic [COLOR_W-1:0] host_wdata,
   input  logic               mode6,
   output logic [COLOR_W-1:0] host_rdata,
   input  logic [ADDR_W-1:0]  pix_idx,
   output logic [WORD_W-1:0]  pix_color
);
   if (ADDR_W < 1 || ADDR_W > COLOR_W) begin : g_bad_addr
      $error("clut_host_port: ADDR_W must be between 1 and COLOR_W");
   end
   if (LOW_W < 1 || LOW_W > COLOR_W) begin : g_bad_low
      $error("clut_host_port: LOW_W must be between 1 and COLOR_W");
   end

   logic              ld_any, do_wr, do_rd, commit, refetch, last;
   logic [ADDR_W-1:0] addr_q, host_raddr;
   logic [WORD_W-1:0] host_rword, commit_word;
   logic [COLOR_W-1:0] cur_byte;
   phase_e            phase_q;

   assign ld_any     = wa_load | ra_load;
   assign do_wr      = data_we & ~ld_any;
   assign do_rd      = data_re & ~ld_any & ~data_we;
   assign commit     = do_wr & last;
   assign refetch    = do_rd & last;
   assign host_raddr = ra_load ? host_wdata[ADDR_W-1:0] : addr_q;

   clut_addr_reg #(.ADDR_W(ADDR_W)) addr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_any),
      .pre_inc  (ra_load & ~wa_load),
      .load_val (host_wdata[ADDR_W-1:0]),
      .inc      (commit | refetch),
      .addr     (addr_q)
   );

   clut_color_seq #(.COLOR_W(COLOR_W)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (ld_any),
      .step_wr     (do_wr),
      .step_rd     (do_rd),
      .wbyte       (host_wdata),
      .fill        ((ra_load & ~wa_load) | refetch),
      .fill_word   (host_rword),
      .phase       (phase_q),
      .last        (last),
      .cur_byte    (cur_byte),
      .commit_word (commit_word)
   );

   clut_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ram_i (
      .clk        (clk),
      .we         (commit),
      .waddr      (addr_q),
      .wdata      (commit_word),
      .host_raddr (host_raddr),
      .host_rword (host_rword),
      .pix_raddr  (pix_idx),
      .pix_rword  (pix_color)
   );

   if (LOW_W == COLOR_W) begin : g_nomask
      assign host_rdata = cur_byte;
   end else begin : g_mask
      assign host_rdata = mode6 ? {{(COLOR_W-LOW_W){1'b0}}, cur_byte[LOW_W-1:0]}
                                : cur_byte;
   end
endmodule

// File: rtl/clut_host_port_chk.sv
module clut_host_port_chk #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned COLOR_W = 8,
   parameter int unsigned LOW_W   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wa_load,
   input logic               ra_load,
   input logic               data_we,
   input logic               data_re,
   input logic [COLOR_W-1:0] host_wdata,
   input logic               mode6,
   input logic [COLOR_W-1:0] host_rdata,
   input logic [ADDR_W-1:0]  addr_q,
   input logic [1:0]         phase_q
);
   // R2
   commit_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !wa_load && !ra_load && phase_q == 2'd2)
      |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)) && (phase_q == 2'd0));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wa_load && !ra_load && !data_we && !data_re)
      |=> $stable(addr_q) && $stable(phase_q));

   // R4
   ra_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_load && !wa_load)
      |=> (addr_q == ADDR_W'($past(host_wdata[ADDR_W-1:0]) + 1'b1)) && (phase_q == 2'd0));

   // R8
   wa_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wa_load |=> (addr_q == $past(host_wdata[ADDR_W-1:0])) && (phase_q == 2'd0));

   // R6
   mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode6 |-> (host_rdata[COLOR_W-1:LOW_W] == '0));

   // R5
   phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q != 2'd3);
endmodule

bind clut_host_port clut_host_port_chk #(
   .ADDR_W(ADDR_W), .COLOR_W(COLOR_W), .LOW_W(LOW_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wa_load    (wa_load),
   .ra_load    (ra_load),
   .data_we    (data_we),
   .data_re    (data_re),
   .host_wdata (host_wdata),
   .mode6      (mode6),
   .host_rdata (host_rdata),
   .addr_q     (addr_q),
   .phase_q    (phase_q)
);

// File: tb/clut_host_port_tb_top.sv
`timescale 1ns/1ps
module clut_host_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wa_load = 0, ra_load = 0, data_we = 0, data_re = 0, mode6 = 0;
   logic [7:0]  host_wdata = 0, pix_idx = 0;
   logic [7:0]  host_rdata;
   logic [23:0] pix_color;
   int          errors = 0, checks = 0;
   logic [23:0] model [256];
   logic [7:0]  model_addr = 0;

   always #2.5 clk = ~clk;

   clut_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .wa_load(wa_load), .ra_load(ra_load),
      .data_we(data_we), .data_re(data_re), .host_wdata(host_wdata),
      .mode6(mode6), .host_rdata(host_rdata), .pix_idx(pix_idx),
      .pix_color(pix_color)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_wa(input logic [7:0] a);
      @(negedge clk); wa_load = 1; host_wdata = a;
      @(negedge clk); wa_load = 0; model_addr = a;
   endtask

   task automatic pulse_ra(input logic [7:0] a);
      @(negedge clk); ra_load = 1; host_wdata = a;
      @(negedge clk); ra_load = 0; model_addr = a + 8'd1;
   endtask

   task automatic wr_byte(input logic [7:0] b);
      @(negedge clk); data_we = 1; host_wdata = b;
      @(negedge clk); data_we = 0;
   endtask

   task automatic wr_entry(input logic [23:0] w);
      wr_byte(w[23:16]); wr_byte(w[15:8]); wr_byte(w[7:0]);
      model[model_addr] = w; model_addr = model_addr + 8'd1;
   endtask

   task automatic rd_byte(output logic [7:0] b);
      @(negedge clk); data_re = 1; #1 b = host_rdata;
      @(negedge clk); data_re = 0;
   endtask

   task automatic rd_entry(input string req, input logic [23:0] exp, input logic m6);
      logic [7:0] b;
      for (int i = 2; i >= 0; i--) begin
         logic [7:0] e;
         e = exp[i*8 +: 8];
         if (m6) e[7:6] = 2'b00;
         rd_byte(b);
         check(req, {24'd0, b}, {24'd0, e});
      end
   endtask

   task automatic t_reset();
      #1 check("R10 reset rdata", {24'd0, host_rdata}, 32'd0);
   endtask

   task automatic t_single();
      pulse_wa(8'd10); wr_entry(24'h12A5F0);
      pulse_ra(8'd10); rd_entry("R1/R4 single entry", 24'h12A5F0, 1'b0);
   endtask

   task automatic t_block();
      pulse_wa(8'd20);
      wr_entry(24'h010203); wr_entry(24'hA0B0C0); wr_entry(24'hFFEE11);
      pulse_ra(8'd20);
      rd_entry("R2/R5 block 20", 24'h010203, 1'b0);
      rd_entry("R2/R5 block 21", 24'hA0B0C0, 1'b0);
      rd_entry("R2/R5 block 22", 24'hFFEE11, 1'b0);
   endtask

   task automatic t_wrap();
      pulse_wa(8'd255); wr_entry(24'h55AA33); wr_entry(24'h0F1E2D);
      pulse_ra(8'd255);
      rd_entry("R3 entry 255", 24'h55AA33, 1'b0);
      rd_entry("R3 wrapped entry 0", 24'h0F1E2D, 1'b0);
   endtask

   task automatic t_mode6();
      mode6 = 1;
      pulse_wa(8'd40); wr_entry(24'hFFC53A);
      pulse_ra(8'd40); rd_entry("R6 masked readback", 24'hFFC53A, 1'b1);
      mode6 = 0;
      pulse_ra(8'd40); rd_entry("R7 full bits kept", 24'hFFC53A, 1'b0);
   endtask

   task automatic t_restart();
      logic [7:0] b;
      pulse_wa(8'd50); wr_entry(24'h112233); wr_entry(24'h445566);
      pulse_wa(8'd50); wr_byte(8'h99); wr_byte(8'h88);
      pulse_wa(8'd51); wr_byte(8'h77);
      pulse_ra(8'd50);
      rd_entry("R8 cut write leaves 50", 24'h112233, 1'b0);
      rd_entry("R8 cut write leaves 51", 24'h445566, 1'b0);
      pulse_ra(8'd51); rd_byte(b);
      pulse_ra(8'd51); rd_byte(b);
      check("R8 read restarts at red", {24'd0, b}, 32'h44);
      pulse_wa(8'd60); wr_byte(8'hDE);
      pulse_wa(8'd60); wr_entry(24'hCAFE01);
      pulse_ra(8'd60); rd_entry("R8 write restarts at red", 24'hCAFE01, 1'b0);
   endtask

   task automatic t_pixel();
      logic [7:0] b;
      @(negedge clk); pix_idx = 8'd10;
      @(negedge clk); @(negedge clk);
      check("R9 pixel 10", {8'd0, pix_color}, {8'd0, model[10]});
      pix_idx = 8'd21;
      @(negedge clk);
      check("R9 pixel 21 one clock later", {8'd0, pix_color}, {8'd0, model[21]});
      pulse_ra(8'd10); rd_byte(b); rd_byte(b); rd_byte(b);
      check("R9 pixel unchanged by host reads", {8'd0, pix_color}, {8'd0, model[21]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_single();
      t_block();
      t_wrap();
      t_mode6();
      t_restart();
      t_pixel();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule